// File: doc/BRIEF.md
# Synchronized Three-Channel PWM Timer Group

This block holds a small group of 16-bit up-counters. Each channel has two compare registers (A and B), a run bit, a group-membership bit and a 3-bit clear selector. Channels that are group members share two actions. A write to any member's counter loads the same value into every member's counter. When a member clears itself on its own compare match, that clear also resets every member whose selector asks for a group clear.

Each channel drives one pulse-width output. The output rises when the counter is cleared and falls on a compare A match. A typical setup has channel 0 clearing on its compare B and channels 1 and 2 set to group clear. This gives three waveforms with one common period, each with its own duty set by its compare A.

Software sets up the group through a single-cycle register write port and sets the run bits last.

Each channel's output is a two-state machine. The states are `OUT_LOW` and `OUT_HIGH`. The transition `OUT_LOW -> OUT_HIGH` is taken on an effective counter clear. The transition `OUT_HIGH -> OUT_LOW` is taken on a compare A match in a cycle with no effective clear. In every other case the machine stays in its current state.

Top module: `sync_pwm_group`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all counters, all compare registers, all selectors, all run bits, all membership bits and all outputs are 0.
- R2: A channel's counter increments by one on each clock only while its run bit is 1. It wraps from 0xFFFF to 0 and holds its value while its run bit is 0.
- R3: Register addresses are fixed.
  - Channel c owns addresses 4c+0 (counter), 4c+1 (compare A), 4c+2 (compare B) and 4c+3 (clear selector in data bits 2:0).
  - Address 12 holds the run bits in data bits 2:0, with bit c for channel c.
  - Address 13 holds the membership bits in data bits 2:0, with bit c for channel c.
- R4: The clear selector is decoded as follows. 000 means no clear. 001 clears to 0 on a compare A match. 010 clears to 0 on a compare B match. 011 selects group clear. Any other value means no clear. A compare match counts only while the channel's run bit is 1.
- R5: A write to a member channel's counter loads the written value into the counters of all member channels at the same edge. A write to a non-member's counter loads only that counter.
- R6: A member channel that clears on its own compare A or B match clears, at the same edge, every member whose selector is 011. A non-member channel with selector 011 is not cleared.
- R7: If a counter write and a clear reach the same counter at one edge, the written value is loaded.
- R8: The output goes to 1 on the edge that clears the counter to 0. It goes to 0 on a compare A match, unless the same edge clears the counter, in which case it is 1.
- R9: Suppose channel 0 has selector 010, all three channels are members, and channels 1 and 2 have selector 011. Then every counter follows t mod (B0+1). After the first clear, each channel's output is 1 exactly while its counter is at most its own compare A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| cnt_out | output | 48 | Counter values, channel c in bits 16c+15:16c |
| pwm_out | output | 3 | Pulse output per channel, bit c for channel c |

## Verification
The hardest case to reach is a counter write that lands on the same edge as a group clear. To hit it, the bench starts a group with a short period and watches channel 0's counter at each falling edge. When that counter equals compare B, the bench drives a write to channel 1's counter in that same half cycle. The write then meets the group clear at the next edge. The output duty rule is also checked near-exhaustively: every compare A from 0 to one past the period end is swept over periods of 2 to 7 clocks, so the cases where the match and the clear share an edge are all covered.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
    localparam logic [2:0] CLR_NONE  = 3'b000;
    localparam logic [2:0] CLR_CMPA  = 3'b001;
    localparam logic [2:0] CLR_CMPB  = 3'b010;
    localparam logic [2:0] CLR_GROUP = 3'b011;

    localparam int unsigned REG_CNT     = 0;
    localparam int unsigned REG_CMPA    = 1;
    localparam int unsigned REG_CMPB    = 2;
    localparam int unsigned REG_CTRL    = 3;
    localparam int unsigned REGS_PER_CH = 4;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } out_state_e;
endpackage

// File: rtl/sync_pwm_regs.sv
module sync_pwm_regs
    import sync_pwm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic [NCH-1:0][CW-1:0]   cmp_a,
    output logic [NCH-1:0][CW-1:0]   cmp_b,
    output logic [NCH-1:0][2:0]      sel,
    output logic [NCH-1:0]           run,
    output logic [NCH-1:0]           sync_en,
    output logic [NCH-1:0]           load,
    output logic [CW-1:0]            load_val
);
    localparam int RUN_ADDR  = REGS_PER_CH * NCH;
    localparam int SYNC_ADDR = RUN_ADDR + 1;

    logic [NCH-1:0] cnt_hit;
    logic           grp_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a   <= '0;
            cmp_b   <= '0;
            sel     <= '0;
            run     <= '0;
            sync_en <= '0;
        end else if (wr_en) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_addr == AW'(ch * REGS_PER_CH + REG_CMPA)) cmp_a[ch] <= wr_data;
                if (wr_addr == AW'(ch * REGS_PER_CH + REG_CMPB)) cmp_b[ch] <= wr_data;
                if (wr_addr == AW'(ch * REGS_PER_CH + REG_CTRL)) sel[ch]   <= wr_data[2:0];
            end
            if (wr_addr == AW'(RUN_ADDR))  run     <= wr_data[NCH-1:0];
            if (wr_addr == AW'(SYNC_ADDR)) sync_en <= wr_data[NCH-1:0];
        end
    end

    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            cnt_hit[ch] = wr_en && (wr_addr == AW'(ch * REGS_PER_CH + REG_CNT));
        end
        grp_hit = |(cnt_hit & sync_en);
        load    = cnt_hit | (sync_en & {NCH{grp_hit}});
    end

    assign load_val = wr_data;
endmodule

// File: rtl/sync_pwm_chan.sv
module sync_pwm_chan
    import sync_pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          sync_en,
    input  logic [2:0]    sel,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          grp_clr,
    output logic          own_clr,
    output logic          clr_eff,
    output logic [CW-1:0] cnt,
    output logic          pwm
);
    out_state_e state, state_nx;
    logic match_a, match_b, clr_req;

    assign match_a = run && (cnt == cmp_a);
    assign match_b = run && (cnt == cmp_b);
    assign own_clr = ((sel == CLR_CMPA) && match_a) || ((sel == CLR_CMPB) && match_b);
    assign clr_req = own_clr || (sync_en && (sel == CLR_GROUP) && grp_clr);
    assign clr_eff = clr_req && !load;

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (load)    cnt <= load_val;
        else if (clr_req) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= OUT_LOW;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_LOW:  if (clr_eff)              state_nx = OUT_HIGH;
            OUT_HIGH: if (!clr_eff && match_a)  state_nx = OUT_LOW;
            default:                            state_nx = OUT_LOW;
        endcase
    end

    always_comb begin
        pwm = (state == OUT_HIGH);
    end
endmodule

// File: rtl/sync_pwm_group.sv
module sync_pwm_group
    import sync_pwm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = $clog2(REGS_PER_CH * NCH + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CW-1:0]       wr_data,
    output logic [NCH*CW-1:0]   cnt_out,
    output logic [NCH-1:0]      pwm_out
);
    logic [NCH-1:0][CW-1:0] cmp_a_q, cmp_b_q;
    logic [NCH-1:0][2:0]    sel_q;
    logic [NCH-1:0]         run_q, sync_q, load, own_clr, clr_eff;
    logic [CW-1:0]          load_val;
    logic                   grp_clr;

    sync_pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .sel(sel_q), .run(run_q),
        .sync_en(sync_q), .load(load), .load_val(load_val)
    );

    assign grp_clr = |(own_clr & sync_q);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sync_pwm_chan #(.CW(CW)) i_chan (
            .clk(clk), .rst(rst), .run(run_q[c]), .sync_en(sync_q[c]),
            .sel(sel_q[c]), .cmp_a(cmp_a_q[c]), .cmp_b(cmp_b_q[c]),
            .load(load[c]), .load_val(load_val), .grp_clr(grp_clr),
            .own_clr(own_clr[c]), .clr_eff(clr_eff[c]),
            .cnt(cnt_out[c*CW +: CW]), .pwm(pwm_out[c])
        );
    end
endmodule

// File: rtl/sync_pwm_group_chk.sv
module sync_pwm_group_chk #(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic [CW-1:0]      wr_data,
    input logic [NCH*CW-1:0]  cnt_out,
    input logic [NCH-1:0]     pwm_out,
    input logic [NCH-1:0]     run_q,
    input logic [NCH-1:0]     sync_q,
    input logic [NCH-1:0][2:0] sel_q,
    input logic               grp_clr,
    input logic [NCH-1:0]     clr_eff
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cnt_out == '0 && pwm_out == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_i
        // R2: stopped channel holds its count
        a_r2_stopped_hold: assert property (@(posedge clk) disable iff (rst)
            (!run_q[i] && !wr_en && !grp_clr) |=> $stable(cnt_out[i*CW +: CW]));

        // R7: own counter write always lands, even against a clear
        a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == AW'(4*i)) |=> (cnt_out[i*CW +: CW] == $past(wr_data)));

        a_r6_group_clear: assert property (@(posedge clk) disable iff (rst)
            (grp_clr && sync_q[i] && sel_q[i] == 3'b011 && !wr_en)
            |=> (cnt_out[i*CW +: CW] == '0));

        a_r8_clear_high: assert property (@(posedge clk) disable iff (rst)
            clr_eff[i] |=> (pwm_out[i] && cnt_out[i*CW +: CW] == '0));

        for (genvar j = 0; j < NCH; j++) begin : g_j
            a_r5_preset: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == AW'(4*j) && sync_q[j] && sync_q[i])
                |=> (cnt_out[i*CW +: CW] == $past(wr_data)));
        end
    end
endmodule

bind sync_pwm_group sync_pwm_group_chk #(.NCH(NCH), .CW(CW), .AW(AW)) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_out(cnt_out), .pwm_out(pwm_out), .run_q(run_q), .sync_q(sync_q),
    .sel_q(sel_q), .grp_clr(grp_clr), .clr_eff(clr_eff)
);

// File: tb/test_sync_pwm_group.sv
module test_sync_pwm_group;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam logic [AW-1:0] A_RUN  = 4'd12;
    localparam logic [AW-1:0] A_SYNC = 4'd13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NCH*CW-1:0] cnt_out;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_pwm_group #(.NCH(NCH), .CW(CW), .AW(AW)) i_sync_pwm_group (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_out(cnt_out), .pwm_out(pwm_out)
    );

    function automatic logic [CW-1:0] cnt_of(int c);
        return cnt_out[c*CW +: CW];
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] keep;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        for (int c = 0; c < NCH; c++) check("R1 counter after reset", cnt_of(c), 0);
        check("R1 outputs after reset", pwm_out, 0);
        step(5);
        check("R2 no count with run bits clear", cnt_out, 0);

        // R2/R3 run bit of channel 1 only
        wr(A_RUN, 16'h2);
        step(10);
        check("R2 ch1 counts while running", cnt_of(1), 10);
        check("R2 ch0 held while stopped", cnt_of(0), 0);
        check("R2 ch2 held while stopped", cnt_of(2), 0);

        // R2 wrap
        wr(A_RUN, 16'h0);
        wr(4'd4, 16'hFFFE);
        check("R3 counter write ch1", cnt_of(1), 16'hFFFE);
        wr(A_RUN, 16'h2);
        step(1);
        check("R2 reaches 0xFFFF", cnt_of(1), 16'hFFFF);
        step(1);
        check("R2 wraps to 0", cnt_of(1), 0);

        // R4 selector 001 on ch2
        wr(A_RUN, 16'h0);
        wr(4'd11, 16'h1);
        wr(4'd9, 16'd4);
        wr(4'd8, 16'd0);
        wr(A_RUN, 16'h4);
        step(4);
        check("R4 sel 001 before match", cnt_of(2), 4);
        step(1);
        check("R4 sel 001 clears on compare A", cnt_of(2), 0);
        step(2);
        check("R4 sel 001 counts after clear", cnt_of(2), 2);

        // R4 invalid selector 101
        wr(A_RUN, 16'h0);
        wr(4'd11, 16'h5);
        wr(4'd9, 16'd2);
        wr(4'd10, 16'd2);
        wr(4'd8, 16'd0);
        wr(A_RUN, 16'h4);
        step(6);
        check("R4 sel 101 never clears", cnt_of(2), 6);

        // R5 preset among members ch0, ch1
        wr(A_RUN, 16'h0);
        wr(A_SYNC, 16'h3);
        keep = cnt_of(2);
        wr(4'd4, 16'h1234);
        check("R5 preset reaches ch0", cnt_of(0), 16'h1234);
        check("R5 preset ch1", cnt_of(1), 16'h1234);
        check("R5 non-member untouched", cnt_of(2), keep);
        wr(4'd8, 16'h0055);
        check("R5 non-member write ch2", cnt_of(2), 16'h0055);
        check("R5 non-member write leaves ch0", cnt_of(0), 16'h1234);

        // R6 group clear, ch2 is 011 but not a member
        wr(4'd3, 16'h2);
        wr(4'd2, 16'd3);
        wr(4'd7, 16'h3);
        wr(4'd11, 16'h3);
        wr(4'd0, 16'd0);
        wr(4'd8, 16'd0);
        wr(A_RUN, 16'h7);
        step(4);
        check("R6 ch0 self clear", cnt_of(0), 0);
        check("R6 member ch1 group cleared", cnt_of(1), 0);
        check("R6 non-member ch2 not cleared", cnt_of(2), 4);
        step(2);
        check("R6 ch1 follows ch0", cnt_of(1), 2);
        step(1);
        check("R6 ch0 at compare B", cnt_of(0), 3);
        // R7: write lands on the clearing edge
        wr_en = 1'b1; wr_addr = 4'd4; wr_data = 16'h0100;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 write beats clear ch0", cnt_of(0), 16'h0100);
        check("R7 write beats group clear ch1", cnt_of(1), 16'h0100);
        check("R7 ch2 keeps counting", cnt_of(2), 8);
        step(1);
        check("R7 ch0 counts on from written value", cnt_of(0), 16'h0101);

        // R8/R9 sweep of period and duty
        for (int b0 = 1; b0 <= 6; b0++) begin
            for (int a0 = 0; a0 <= b0 + 1; a0++) begin
                int p;
                int av[NCH];
                p = b0 + 1;
                av[0] = a0;
                av[1] = (a0 + 1) % (b0 + 2);
                av[2] = (a0 + 2) % (b0 + 2);
                wr(A_RUN, 16'h0);
                wr(A_SYNC, 16'h7);
                wr(4'd3, 16'h2);
                wr(4'd7, 16'h3);
                wr(4'd11, 16'h3);
                wr(4'd2, 16'(b0));
                for (int c = 0; c < NCH; c++) wr(AW'(4*c + 1), 16'(av[c]));
                wr(4'd0, 16'd0);
                wr(A_RUN, 16'h7);
                for (int t = 1; t <= 3 * p; t++) begin
                    step(1);
                    for (int c = 0; c < NCH; c++) begin
                        check("R9 shared period counter", cnt_of(c), t % p);
                        if (t >= p)
                            check("R8 output duty", pwm_out[c], ((t % p) <= av[c]) ? 1 : 0);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule